// File: doc/BRIEF.md
# Thresholded Event Counter

This block is one programmable performance-monitoring counter. Every clock it receives, from a bank of event sources, a small count of how many events happened in that cycle, together with the current privilege level. A configuration word picks one source and a set of its sub-lanes and then decides how each cycle is counted. The counter can add the raw per-cycle count. It can add one in each cycle whose count reaches a programmable threshold, or in each cycle whose count stays below that threshold. It can also add one only when that condition turns from false to true.

Software can preload the counter with the two's complement of a sample interval, so that the counter wraps after exactly that many qualified increments. On a wrap the block sets a sticky overflow flag. When interrupts are enabled it also raises a one-cycle interrupt request. The block has no halt input, so qualified events are counted in every cycle, halted or not, as long as the source reports them.

Top module: `thresh_event_counter`

## Requirements
- R1: After a synchronous active-low reset, `count_value`, `ovf_status` and `irq` are zero, and the configuration word is zero, so nothing is counted.
- R2: While configuration bit 0 (enable) is clear, the counter never changes except through a counter write.
- R3: With the threshold field (configuration bits 13:6) equal to zero, each qualified cycle adds the selected per-cycle count (0 to 7) to the counter. The invert and edge bits have no effect in this case.
- R4: With a nonzero threshold and invert (bit 4) clear, each qualified cycle whose selected count is greater than or equal to the threshold adds exactly one.
- R5: With a nonzero threshold and invert set, each qualified cycle whose selected count is below the threshold adds one. Threshold 1 with invert therefore counts the cycles with zero events.
- R6: With a nonzero threshold and edge mode (bit 3) set, one is added only when the threshold condition is true in this cycle and was false in the previous cycle. The previous-cycle condition is tracked in every cycle, whatever the gating, and is false after reset.
- R7: A cycle is qualified only when enable is set and either the privilege level is 3 with user enable (bit 1) set, or the level is 0 with kernel enable (bit 2) set. Levels 1 and 2 are never counted.
- R8: Configuration bits 21:14 select source s, and bits 29:22 form a mask over that source's eight 3-bit lanes, where lane j sits at bits (s*8+j)*3+2:(s*8+j)*3 of `src_counts`. The selected count is the sum of the masked lanes, saturated at 7. A source number at or above `NUM_SRC` gives a count of 0.
- R9: A counter write (`cnt_wr`) loads `cnt_wdata` at the next clock edge, and takes priority over any increment in that cycle.
- R10: An increment that carries past the all-ones value wraps the counter and sets `ovf_status`. The flag then stays set until `stat_clr` is asserted. A wrap in the same cycle as a clear leaves the flag set.
- R11: `irq` is high for exactly the one cycle that follows a wrapping edge, and only if interrupt enable (bit 5) was set when the wrap happened.
- R12: A configuration write (`cfg_wr`) takes effect from the next cycle. The cycle in which the write occurs is still counted under the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_counts | input | NUM_SRC*8*3 | Per-cycle event counts, eight 3-bit lanes per source |
| priv_level | input | 2 | Current privilege level (0 kernel, 3 user) |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 30 | Configuration word to write |
| cnt_wr | input | 1 | Write strobe for the counter value |
| cnt_wdata | input | CNT_W | Counter value to load |
| stat_clr | input | 1 | Clears the sticky overflow flag |
| count_value | output | CNT_W | Current counter value |
| ovf_status | output | 1 | Sticky overflow flag |
| irq | output | 1 | One-cycle overflow interrupt request |

## Verification
The bench builds the block with four sources and a 16-bit counter. The narrow counter lets a full wrap from zero happen at seven per cycle in under ten thousand cycles. It also lets preloads near the all-ones value make overflow, sticky clearing and clear-versus-wrap collisions occur many times. With four sources, source numbers 4 and above exercise the out-of-range selection. Lane masks of one, a few or all eight lanes move the selected count from sparse values, where thresholds, inversion and edges matter, to saturation at 7.

// File: rtl/tec_pkg.sv
// Shared types for the thresholded event counter.
// Assumes: per-cycle counts are 3 bits wide and each source has eight lanes.
package tec_pkg;
    localparam int EV_W   = 3;
    localparam int LANES  = 8;
    localparam int CFG_W  = 30;

    localparam logic [1:0] PRIV_KERNEL = 2'd0;
    localparam logic [1:0] PRIV_USER   = 2'd3;

    // Configuration word, most significant field first.
    typedef struct packed {
        logic [7:0] umask;     // 29:22 lane mask
        logic [7:0] evsel;     // 21:14 source number
        logic [7:0] thresh;    // 13:6  threshold, zero means raw add
        logic       int_en;    // 5
        logic       invert;    // 4
        logic       edge_mode; // 3
        logic       kern_en;   // 2
        logic       user_en;   // 1
        logic       enable;    // 0
    } tec_cfg_t;
endpackage

// File: rtl/tec_event_select.sv
// Picks one source and sums the masked lanes of that source.
// The sum saturates at the largest per-cycle count. A source number
// outside the bank gives zero. Purely combinational.
module tec_event_select
    import tec_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC*LANES*EV_W-1:0] src_flat,
    input  logic [7:0]                    evsel,
    input  logic [7:0]                    umask,
    output logic [EV_W-1:0]               sel_count
);
    localparam int SUM_W   = EV_W + $clog2(LANES + 1);
    localparam int SAT_MAX = (1 << EV_W) - 1;

    logic [EV_W-1:0]  lanes [NUM_SRC][LANES];
    logic [SUM_W-1:0] lane_sum;

    // Unpack the flat source bus into a per-source, per-lane array.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            assign lanes[s][j] = src_flat[(s*LANES+j)*EV_W +: EV_W];
        end
    end

    // Sum the masked lanes of the selected source.
    always_comb begin
        lane_sum = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int j = 0; j < LANES; j++) begin
                if (evsel == 8'(s) && umask[j])
                    lane_sum = lane_sum + SUM_W'(lanes[s][j]);
            end
        end
    end

    // Clamp the sum to the per-cycle count range.
    always_comb begin
        if (lane_sum > SUM_W'(SAT_MAX))
            sel_count = EV_W'(SAT_MAX);
        else
            sel_count = lane_sum[EV_W-1:0];
    end
endmodule

// File: rtl/tec_qualifier.sv
// Turns the selected per-cycle count into this cycle's increment.
// It applies privilege gating, the enable bit, the threshold compare,
// inversion and edge detection. It holds one flop: the threshold
// condition of the previous cycle, updated every cycle.
module tec_qualifier
    import tec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  tec_cfg_t        cfg,
    input  logic [EV_W-1:0] ev_count,
    input  logic [1:0]      priv,
    output logic [EV_W-1:0] inc_amt
);
    logic meets;
    logic cond;
    logic cond_prev;
    logic priv_ok;

    // Threshold compare with optional inversion.
    always_comb begin
        meets = (8'(ev_count) >= cfg.thresh);
        cond  = cfg.invert ? !meets : meets;
    end

    // Privilege level qualification.
    always_comb begin
        priv_ok = (priv == PRIV_USER   && cfg.user_en) ||
                  (priv == PRIV_KERNEL && cfg.kern_en);
    end

    // Select the increment for this cycle.
    always_comb begin
        if (!cfg.enable || !priv_ok)
            inc_amt = '0;
        else if (cfg.thresh == 8'd0)
            inc_amt = ev_count;
        else if (cfg.edge_mode)
            inc_amt = EV_W'(cond && !cond_prev);
        else
            inc_amt = EV_W'(cond);
    end

    // Remember the condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cond_prev <= 1'b0;
        else
            cond_prev <= cond;
    end
endmodule

// File: rtl/tec_accum.sv
// Counter register with preload, wrap detection, sticky overflow flag
// and a one-cycle interrupt pulse. A load overrides the increment and
// never reports a wrap.
module tec_accum
    import tec_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [EV_W-1:0]  inc_amt,
    input  logic             int_en,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             irq
);
    logic [CNT_W:0] sum;
    logic           wrap;

    // Add with one extra bit to catch the carry out.
    always_comb begin
        sum  = {1'b0, count} + (CNT_W+1)'(inc_amt);
        wrap = !load && sum[CNT_W];
    end

    // Update counter, sticky flag and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            count <= load ? load_val : sum[CNT_W-1:0];
            ovf   <= wrap || (ovf && !ovf_clr);
            irq   <= wrap && int_en;
        end
    end
endmodule

// File: rtl/thresh_event_counter.sv
// Top of the thresholded event counter. Holds the configuration word
// and wires the selector, the qualifier and the accumulator together.
// Assumes the register write strobes are single-cycle and synchronous.
module thresh_event_counter
    import tec_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC*LANES*EV_W-1:0] src_counts,
    input  logic [1:0]                    priv_level,
    input  logic                          cfg_wr,
    input  logic [CFG_W-1:0]              cfg_wdata,
    input  logic                          cnt_wr,
    input  logic [CNT_W-1:0]              cnt_wdata,
    input  logic                          stat_clr,
    output logic [CNT_W-1:0]              count_value,
    output logic                          ovf_status,
    output logic                          irq
);
    tec_cfg_t        cfg_q;
    logic [EV_W-1:0] sel_count;
    logic [EV_W-1:0] inc_amt;

    // Configuration register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= tec_cfg_t'(cfg_wdata);
    end

    tec_event_select #(.NUM_SRC(NUM_SRC)) u_sel (
        .src_flat  (src_counts),
        .evsel     (cfg_q.evsel),
        .umask     (cfg_q.umask),
        .sel_count (sel_count)
    );

    tec_qualifier u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .ev_count (sel_count),
        .priv     (priv_level),
        .inc_amt  (inc_amt)
    );

    tec_accum #(.CNT_W(CNT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .inc_amt  (inc_amt),
        .int_en   (cfg_q.int_en),
        .ovf_clr  (stat_clr),
        .count    (count_value),
        .ovf      (ovf_status),
        .irq      (irq)
    );
endmodule

// File: rtl/tec_checker.sv
// Temporal checks on the thresholded event counter, bound to its top.
module tec_checker #(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             stat_clr,
    input logic [1:0]       priv_level,
    input logic             cfg_enable,
    input logic             cfg_int_en,
    input logic [7:0]       cfg_thresh,
    input logic [CNT_W-1:0] count_value,
    input logic             ovf_status,
    input logic             irq
);
    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !cnt_wr) |=> $stable(count_value));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_thresh != 8'd0 && !cnt_wr) |=>
        (CNT_W'(count_value - $past(count_value)) <= CNT_W'(1)));

    assert_priv_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_level == 2'd1 || priv_level == 2'd2) && !cnt_wr) |=> $stable(count_value));

    assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_value == $past(cnt_wdata)));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_status && !stat_clr) |=> ovf_status);

    assert_irq_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_status);

    assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_int_en));
endmodule

bind thresh_event_counter tec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (cnt_wdata),
    .stat_clr    (stat_clr),
    .priv_level  (priv_level),
    .cfg_enable  (cfg_q.enable),
    .cfg_int_en  (cfg_q.int_en),
    .cfg_thresh  (cfg_q.thresh),
    .count_value (count_value),
    .ovf_status  (ovf_status),
    .irq         (irq)
);

// File: tb/thresh_event_counter_test.sv
// Bench: behavioural reference model compared with the outputs every clock.
module thresh_event_counter_test;
    localparam int NUM_SRC  = 4;
    localparam int CNT_W    = 16;
    localparam int SRC_BITS = NUM_SRC * 8 * 3;
    localparam longint MODV = 64'd1 << CNT_W;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [SRC_BITS-1:0] src_counts;
    logic [1:0]          priv_level;
    logic                cfg_wr;
    logic [29:0]         cfg_wdata;
    logic                cnt_wr;
    logic [CNT_W-1:0]    cnt_wdata;
    logic                stat_clr;
    logic [CNT_W-1:0]    count_value;
    logic                ovf_status;
    logic                irq;

    always #5 clk = ~clk;

    thresh_event_counter #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .src_counts(src_counts), .priv_level(priv_level),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .stat_clr(stat_clr), .count_value(count_value), .ovf_status(ovf_status), .irq(irq)
    );

    int     checks = 0;
    int     errors = 0;
    string  tag = "R1";
    bit     done = 0;

    bit [29:0] m_cfg;
    longint    m_cnt;
    bit        m_ovf, m_irq, m_prev;

    function automatic bit [29:0] mk(bit en, bit ue, bit ke, bit ed, bit iv, bit ie,
                                     int thr, int ev, int um);
        bit [29:0] w = '0;
        w[0] = en; w[1] = ue; w[2] = ke; w[3] = ed; w[4] = iv; w[5] = ie;
        w[13:6] = 8'(thr); w[21:14] = 8'(ev); w[29:22] = 8'(um);
        return w;
    endfunction

    function automatic int lane(int s, int j);
        return int'(src_counts[(s*8+j)*3 +: 3]);
    endfunction

    task automatic model_step();
        int c = 0;
        int thr = int'(m_cfg[13:6]);
        int ev  = int'(m_cfg[21:14]);
        int inc = 0;
        bit meets, cond, pok, carry = 0;
        if (ev < NUM_SRC)
            for (int j = 0; j < 8; j++)
                if (m_cfg[22+j]) c += lane(ev, j);
        if (c > 7) c = 7;
        meets = (c >= thr);
        cond  = m_cfg[4] ? !meets : meets;
        pok   = (priv_level == 2'd3 && m_cfg[1]) || (priv_level == 2'd0 && m_cfg[2]);
        if (m_cfg[0] && pok) begin
            if (thr == 0)       inc = c;
            else if (m_cfg[3])  inc = (cond && !m_prev) ? 1 : 0;
            else                inc = cond ? 1 : 0;
        end
        m_prev = cond;
        if (cnt_wr) m_cnt = longint'(cnt_wdata);
        else begin
            m_cnt += inc;
            if (m_cnt >= MODV) begin m_cnt -= MODV; carry = 1; end
        end
        m_irq = carry && m_cfg[5];
        if (carry) m_ovf = 1;
        else if (stat_clr) m_ovf = 0;
        if (cfg_wr) m_cfg = cfg_wdata;
    endtask

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(longint'(count_value) == m_cnt, "count", longint'(count_value), m_cnt);
        check(ovf_status == m_ovf, "ovf_status", longint'(ovf_status), longint'(m_ovf));
        check(irq == m_irq, "irq", longint'(irq), longint'(m_irq));
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_cfg = '0; m_cnt = 0; m_ovf = 0; m_irq = 0; m_prev = 0;
        end else model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic fill(int maxv);
        for (int k = 0; k < NUM_SRC*8; k++) src_counts[k*3 +: 3] = 3'($urandom_range(0, maxv));
    endtask

    task automatic run(int n, int maxv);
        for (int i = 0; i < n; i++) begin fill(maxv); tick(); end
    endtask

    task automatic write_cfg(bit [29:0] v);
        cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0;
    endtask

    task automatic write_cnt(longint v);
        cnt_wr = 1; cnt_wdata = CNT_W'(v); tick(); cnt_wr = 0;
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL %s watchdog actual=expired expected=finished", tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; src_counts = '0; priv_level = 2'd3; cfg_wr = 0; cfg_wdata = '0;
        cnt_wr = 0; cnt_wdata = '0; stat_clr = 0;
        @(negedge clk);
        tick(); tick();
        // R1: reset values
        check(count_value == '0 && !ovf_status && !irq, "reset outputs",
              longint'(count_value), 0);
        rst_n = 1;
        tag = "R1"; run(5, 7);

        tag = "R2"; write_cfg(mk(0,1,1,0,0,0, 0, 0, 8'hFF)); run(20, 7);

        tag = "R12"; cfg_wr = 1; cfg_wdata = mk(1,1,0,0,0,0, 0, 1, 8'h03); fill(7); tick();
        cfg_wr = 0; run(4, 7);

        tag = "R3"; write_cfg(mk(1,1,0,1,1,0, 0, 2, 8'h01)); run(30, 7);
        write_cfg(mk(1,1,0,0,0,0, 0, 3, 8'h05)); run(30, 3);

        tag = "R4"; write_cfg(mk(1,1,0,0,0,0, 3, 0, 8'h01)); run(40, 7);
        write_cfg(mk(1,1,0,0,0,0, 7, 1, 8'h0F)); run(30, 3);
        write_cfg(mk(1,1,0,0,0,0, 9, 1, 8'hFF)); run(10, 7);

        tag = "R5"; write_cfg(mk(1,1,0,0,1,0, 1, 0, 8'h01)); run(40, 2);
        write_cfg(mk(1,1,0,0,1,0, 4, 2, 8'h03)); run(40, 3);

        tag = "R6"; write_cfg(mk(1,1,0,1,0,0, 2, 0, 8'h01)); run(50, 3);
        write_cfg(mk(1,1,0,1,1,0, 1, 1, 8'h01)); run(50, 1);
        src_counts = '1; tick(); tick(); tick();

        tag = "R7";
        for (int p = 0; p < 4; p++) begin
            priv_level = 2'(p);
            write_cfg(mk(1,1,0,0,0,0, 0, 0, 8'h01)); run(8, 7);
            write_cfg(mk(1,0,1,0,0,0, 0, 0, 8'h01)); run(8, 7);
            write_cfg(mk(1,1,1,0,0,0, 0, 0, 8'h01)); run(8, 7);
            write_cfg(mk(1,0,0,0,0,0, 0, 0, 8'h01)); run(8, 7);
        end
        priv_level = 2'd0;

        tag = "R8";
        write_cfg(mk(1,0,1,0,0,0, 0, 5, 8'hFF)); run(10, 7);
        write_cfg(mk(1,0,1,0,0,0, 0, 200, 8'hFF)); run(10, 7);
        write_cfg(mk(1,0,1,0,0,0, 0, 3, 8'h80)); run(15, 7);
        write_cfg(mk(1,0,1,0,0,0, 0, 2, 8'h24)); run(15, 3);
        write_cfg(mk(1,0,1,0,0,0, 0, 1, 8'hFF)); run(15, 1);
        write_cfg(mk(1,0,1,0,0,0, 0, 0, 8'h00)); run(10, 7);

        tag = "R9";
        write_cfg(mk(1,0,1,0,0,0, 0, 0, 8'hFF));
        src_counts = '1; write_cnt(16'h1234); tick();
        write_cnt(16'hABCD); write_cnt(16'h0005); run(5, 7);

        tag = "R10"; write_cfg(mk(1,0,1,0,0,0, 0, 0, 8'h01));
        write_cnt(MODV - 10); run(12, 7); run(5, 7);
        stat_clr = 1; tick(); stat_clr = 0; run(3, 7);
        write_cnt(MODV - 1); src_counts = '1; stat_clr = 1; tick(); stat_clr = 0; run(2, 7);

        tag = "R11"; write_cfg(mk(1,0,1,0,0,1, 0, 0, 8'h01));
        stat_clr = 1; tick(); stat_clr = 0;
        write_cnt(MODV - 5); src_counts = '1; run(1, 7); tick(); tick(); tick();
        write_cfg(mk(1,0,1,0,0,0, 2, 0, 8'hFF));
        write_cnt(MODV - 2); run(6, 7);

        tag = "R10"; stat_clr = 1; tick(); stat_clr = 0;
        write_cfg(mk(1,0,1,0,0,1, 0, 0, 8'hFF)); write_cnt(0);
        src_counts = '1;
        for (int i = 0; i < 9400; i++) tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule